// File: doc/BRIEF.md
# Auto-Baud Rate Detector

This block measures the bit period of an incoming 0x55 sync character on a receive line that is already synchronized to the system clock. It turns that period into a divisor for a baud generator that oversamples 16 times per bit. Software arms a measurement with a one-cycle pulse. The active flag stays up until the measurement ends, then clears itself. At the end the block either presents a new divisor with a load strobe, or reports that its counter would have saturated.

The 0x55 pattern, sent LSB first after a low start bit, has five rising edges. The block counts clock cycles from the first of them (end of the start bit) to the fifth (start of the stop bit), which spans eight bit times. Four low and four high bits fall inside that window, so an uneven duty cycle on the line averages out.

A break-skip option, captured when the block is armed, handles a frame that opens with a long low break. In that mode the block waits for a low run of at least `BRK_MIN` clocks and flags it as a framing error. It then waits for the line to return high, clears the break-skip flag, and only then looks for the sync start bit. Without this option, a break followed by its high delimiter is taken as the start of the sync character, and the result comes out too large.

Top module: `abd_autobaud`

## Requirements
- R1: While rst_ni is low, every output is 0: divisor, load strobe, done, active, break-skip flag, framing error and overflow.
- R2: An arm_i pulse sets active_o, clears done_o, ovf_o and ferr_o, and copies brk_skip_i into brk_skip_o. An arm pulse in the same cycle as the completing fifth rising edge restarts the measurement: there is no load, and active_o stays 1.
- R3: After arming without break-skip, the block waits for a falling edge and then a rising edge of rx_i. That rising edge opens the measurement window. Until the window closes, active_o stays 1.
- R4: Let N be the number of clocks from the clock that first samples rx_i high at the first rising edge to the clock that first samples it high at the fifth. In that fifth clock's update, div_o becomes floor(N/128), load_o pulses for one cycle, done_o becomes 1 and active_o becomes 0.
- R5: Both the low and the high bits inside the window count toward N. With low bits of L clocks and high bits of H clocks, div_o = floor(4*(L+H)/128).
- R6: In break-skip mode, ferr_o is set on the BRK_MIN-th consecutive low sample of rx_i. A shorter low run sets nothing, and the low-run count restarts.
- R7: After a break has been recognized, brk_skip_o clears on the first high sample of rx_i. The block then looks for the sync start bit as in R3.
- R8: Without break-skip, a break of B clocks followed by a delimiter of D clocks and a sync with bit period P gives N = D + 7P, not 8P.
- R9: If N reaches 2^CNT_W-1 before the fifth rising edge, ovf_o is set and active_o clears. There is no load, and div_o keeps its previous value.
- R10: While active_o is 0, activity on rx_i leaves div_o unchanged and load_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Synchronized receive line, idle high |
| arm_i | input | 1 | One-cycle pulse that starts a measurement |
| brk_skip_i | input | 1 | Break-skip request, sampled with arm_i |
| div_o | output | CNT_W-7 (9) | Measured divisor for the 16x generator |
| load_o | output | 1 | One-cycle strobe when div_o takes a new value |
| done_o | output | 1 | Last measurement completed with a load |
| active_o | output | 1 | Measurement armed and in progress (self-clearing) |
| brk_skip_o | output | 1 | Break-skip still pending (self-clearing) |
| ferr_o | output | 1 | Break recognized as a framing error |
| ovf_o | output | 1 | Counter saturated before the fifth rising edge |

## Verification
A re-arm pulse can arrive in the very clock in which the fifth rising edge would complete the measurement. The two actions conflict: one loads a divisor and drops the active flag, the other restarts. The bench raises arm_i at the same falling clock edge at which it drives the stop-bit rise. The run passes only if no load strobe appears, the divisor holds, active stays high, and a later sync character completes normally. The per-cycle reference model, built from edge timestamps, makes the same decision in that clock and is compared against every output on every cycle.

// File: rtl/abd_pkg.sv
package abd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BRK_LOW,
    ST_BRK_HI,
    ST_SEEK_FALL,
    ST_SEEK_RISE,
    ST_MEAS
  } abd_state_e;

  // 0x55 LSB first: bit times between first and fifth rising edge
  localparam int unsigned SPAN_BITS  = 8;
  // rising edges still expected after the one that opens the window
  localparam int unsigned LATE_RISES = 4;
endpackage

// File: rtl/abd_edge.sv
module abd_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rise_o,
  output logic fall_o
);
  logic rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= 1'b1;
    else         rx_q <= rx_i;
  end

  assign rise_o = rx_i & ~rx_q;
  assign fall_o = ~rx_i & rx_q;
endmodule

// File: rtl/abd_count.sv
module abd_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             one_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (one_i) cnt_o <= CNT_W'(1);
    else if (inc_i) cnt_o <= cnt_o + CNT_W'(1);
  end

  assign full_o = &cnt_o;

  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !one_i) |-> !full_o) else $error("counter wrapped"); // R9
endmodule

// File: rtl/abd_ctrl.sv
module abd_ctrl
  import abd_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned OVS     = 16,
  parameter int unsigned BRK_MIN = 1024,
  localparam int unsigned SHIFT  = $clog2(SPAN_BITS * OVS),
  localparam int unsigned DIV_W  = CNT_W - SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             brk_skip_i,
  input  logic             rx_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             full_i,
  output logic             clr_o,
  output logic             one_o,
  output logic             inc_o,
  output logic [DIV_W-1:0] div_o,
  output logic             load_o,
  output logic             done_o,
  output logic             active_o,
  output logic             brk_skip_o,
  output logic             ferr_o,
  output logic             ovf_o
);
  localparam int unsigned RE_W = $clog2(LATE_RISES);
  localparam logic [CNT_W-1:0] BRK_LAST = CNT_W'(BRK_MIN - 1);
  localparam logic [RE_W-1:0]  RE_LAST  = RE_W'(LATE_RISES - 1);

  abd_state_e state_q, state_d;
  logic [RE_W-1:0] redge_q, redge_d;
  logic fin, sat, brk_hit, skip_done;

  always_comb begin
    state_d   = state_q;
    redge_d   = redge_q;
    clr_o     = 1'b0;
    one_o     = 1'b0;
    inc_o     = 1'b0;
    fin       = 1'b0;
    sat       = 1'b0;
    brk_hit   = 1'b0;
    skip_done = 1'b0;
    if (arm_i) begin
      clr_o   = 1'b1;
      state_d = brk_skip_i ? ST_BRK_LOW : ST_SEEK_FALL;
    end else begin
      unique case (state_q)
        ST_BRK_LOW: begin
          if (rx_i) clr_o = 1'b1;
          else if (cnt_i == BRK_LAST) begin
            brk_hit = 1'b1;
            state_d = ST_BRK_HI;
          end else inc_o = 1'b1;
        end
        ST_BRK_HI: if (rx_i) begin
          skip_done = 1'b1;
          state_d   = ST_SEEK_FALL;
        end
        ST_SEEK_FALL: if (fall_i) state_d = ST_SEEK_RISE;
        ST_SEEK_RISE: if (rise_i) begin
          one_o   = 1'b1;
          redge_d = '0;
          state_d = ST_MEAS;
        end
        ST_MEAS: begin
          if (rise_i && redge_q == RE_LAST) begin
            fin     = 1'b1;
            state_d = ST_IDLE;
          end else if (full_i) begin
            sat     = 1'b1;
            state_d = ST_IDLE;
          end else begin
            inc_o = 1'b1;
            if (rise_i) redge_d = redge_q + RE_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      redge_q    <= '0;
      div_o      <= '0;
      load_o     <= 1'b0;
      done_o     <= 1'b0;
      brk_skip_o <= 1'b0;
      ferr_o     <= 1'b0;
      ovf_o      <= 1'b0;
    end else begin
      state_q <= state_d;
      redge_q <= redge_d;
      load_o  <= fin;
      if (arm_i) begin
        brk_skip_o <= brk_skip_i;
        done_o     <= 1'b0;
        ferr_o     <= 1'b0;
        ovf_o      <= 1'b0;
      end else begin
        if (fin) begin
          done_o <= 1'b1;
          div_o  <= cnt_i[CNT_W-1:SHIFT];
        end
        if (sat)       ovf_o      <= 1'b1;
        if (brk_hit)   ferr_o     <= 1'b1;
        if (skip_done) brk_skip_o <= 1'b0;
      end
    end
  end

  assign active_o = (state_q != ST_IDLE);

  AST_ARM_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (active_o && !done_o && !ovf_o)) else $error("arm not taken"); // R2
  AST_LOAD_ENDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> (!active_o && done_o)) else $error("load without completion"); // R4
  AST_DIV_ONLY_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_o |-> $stable(div_o)) else $error("divisor moved without load"); // R10
  AST_OVF_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> !load_o) else $error("load after overflow"); // R9
  AST_SKIP_CLEAR_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(brk_skip_o) && !$past(arm_i)) |-> ($past(rx_i) && ferr_o))
    else $error("break-skip cleared without break and high line"); // R7
endmodule

// File: rtl/abd_autobaud.sv
module abd_autobaud
  import abd_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned OVS     = 16,
  parameter int unsigned BRK_MIN = 1024,
  localparam int unsigned DIV_W  = CNT_W - $clog2(SPAN_BITS * OVS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             arm_i,
  input  logic             brk_skip_i,
  output logic [DIV_W-1:0] div_o,
  output logic             load_o,
  output logic             done_o,
  output logic             active_o,
  output logic             brk_skip_o,
  output logic             ferr_o,
  output logic             ovf_o
);
  logic rise, fall, clr, one, inc, full;
  logic [CNT_W-1:0] cnt;

  abd_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  abd_count #(.CNT_W(CNT_W)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .one_i  (one),
    .inc_i  (inc),
    .cnt_o  (cnt),
    .full_o (full)
  );

  abd_ctrl #(.CNT_W(CNT_W), .OVS(OVS), .BRK_MIN(BRK_MIN)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm_i),
    .brk_skip_i (brk_skip_i),
    .rx_i       (rx_i),
    .rise_i     (rise),
    .fall_i     (fall),
    .cnt_i      (cnt),
    .full_i     (full),
    .clr_o      (clr),
    .one_o      (one),
    .inc_o      (inc),
    .div_o      (div_o),
    .load_o     (load_o),
    .done_o     (done_o),
    .active_o   (active_o),
    .brk_skip_o (brk_skip_o),
    .ferr_o     (ferr_o),
    .ovf_o      (ovf_o)
  );
endmodule

// File: tb/abd_autobaud_tb_top.sv
module abd_autobaud_tb_top;
  localparam int CNT_W   = 16;
  localparam int BRK_MIN = 1024;
  localparam longint SAT = (64'd1 << CNT_W) - 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_i = 1'b1;
  logic arm_i = 1'b0;
  logic brk_skip_i = 1'b0;
  logic [CNT_W-8:0] div_o;
  logic load_o, done_o, active_o, brk_skip_o, ferr_o, ovf_o;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  abd_autobaud #(.CNT_W(CNT_W), .OVS(16), .BRK_MIN(BRK_MIN)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_i), .arm_i(arm_i), .brk_skip_i(brk_skip_i),
    .div_o(div_o), .load_o(load_o), .done_o(done_o), .active_o(active_o),
    .brk_skip_o(brk_skip_o), .ferr_o(ferr_o), .ovf_o(ovf_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: phase number plus edge timestamps
  int     m_ph, m_low, m_nr, e_div;
  longint m_t, m_t1;
  bit     m_prev, e_load, e_done, e_act, e_skip, e_ferr, e_ovf;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_low = 0; m_nr = 0; m_t = 0; m_t1 = 0; m_prev = 1'b1;
      e_div = 0; e_load = 0; e_done = 0; e_act = 0; e_skip = 0; e_ferr = 0; e_ovf = 0;
    end else begin
      bit r, up, dn;
      r  = rx_i;
      up = r && !m_prev;
      dn = !r && m_prev;
      e_load = 1'b0;
      if (arm_i) begin
        e_act = 1; e_skip = brk_skip_i; e_done = 0; e_ovf = 0; e_ferr = 0;
        m_low = 0; m_ph = brk_skip_i ? 1 : 3;
      end else begin
        case (m_ph)
          1: if (!r) begin
               m_low++;
               if (m_low == BRK_MIN) begin e_ferr = 1; m_ph = 2; end
             end else m_low = 0;
          2: if (r) begin e_skip = 0; m_ph = 3; end
          3: if (dn) m_ph = 4;
          4: if (up) begin m_ph = 5; m_t1 = m_t; m_nr = 1; end
          5: begin
               if (up) m_nr++;
               if (m_nr == 5) begin
                 e_div = int'((m_t - m_t1) / 128); e_load = 1; e_done = 1; e_act = 0; m_ph = 0;
               end else if (m_t - m_t1 == SAT) begin
                 e_ovf = 1; e_act = 0; m_ph = 0;
               end
             end
          default: ;
        endcase
      end
      m_prev = r;
      m_t++;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      chk("R4", "div_o", int'(div_o), e_div);
      chk("R4", "load_o", int'(load_o), int'(e_load));
      chk("R4", "done_o", int'(done_o), int'(e_done));
      chk("R3", "active_o", int'(active_o), int'(e_act));
      chk("R7", "brk_skip_o", int'(brk_skip_o), int'(e_skip));
      chk("R6", "ferr_o", int'(ferr_o), int'(e_ferr));
      chk("R9", "ovf_o", int'(ovf_o), int'(e_ovf));
    end
  end

  task automatic drive(bit v, int n);
    rx_i = v;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic arm(bit skip);
    arm_i = 1'b1; brk_skip_i = skip;
    @(negedge clk_i);
    arm_i = 1'b0; brk_skip_i = 1'b0;
  endtask

  // 0x55, LSB first; collide raises arm_i with the stop-bit rise
  task automatic send_sync(int lo, int hi, bit collide);
    drive(1'b0, lo);
    for (int i = 0; i < 8; i++) begin
      if (((8'h55 >> i) & 8'h01) != 0) drive(1'b1, hi);
      else drive(1'b0, lo);
    end
    rx_i = 1'b1;
    if (collide) arm_i = 1'b1;
    @(negedge clk_i);
    arm_i = 1'b0;
    repeat (hi - 1) @(negedge clk_i);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", "reset div", int'(div_o), 0);
    chk("R1", "reset flags", int'({load_o, done_o, active_o, brk_skip_o, ferr_o, ovf_o}), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);

    // R10: sync with nothing armed
    send_sync(160, 160, 1'b0);
    drive(1'b1, 20);
    chk("R10", "div unarmed", int'(div_o), 0);
    chk("R10", "done unarmed", int'(done_o), 0);

    // R3/R4: plain measurement, period 160 -> 10
    arm(1'b0);
    drive(1'b1, 20);
    chk("R3", "active waiting", int'(active_o), 1);
    send_sync(160, 160, 1'b0);
    drive(1'b1, 20);
    chk("R4", "div p160", int'(div_o), 10);
    chk("R4", "done p160", int'(done_o), 1);

    // R4: period 208 -> 13
    arm(1'b0);
    send_sync(208, 208, 1'b0);
    drive(1'b1, 20);
    chk("R4", "div p208", int'(div_o), 13);

    // R5: low 100, high 200 -> 1200/128 = 9
    arm(1'b0);
    send_sync(100, 200, 1'b0);
    drive(1'b1, 20);
    chk("R5", "div asym", int'(div_o), 9);

    // R6/R7: break-skip
    arm(1'b1);
    drive(1'b1, 50);
    drive(1'b0, 300);
    chk("R6", "short low no ferr", int'(ferr_o), 0);
    drive(1'b1, 100);
    drive(1'b0, 2080);
    chk("R6", "break ferr", int'(ferr_o), 1);
    chk("R7", "skip held while low", int'(brk_skip_o), 1);
    drive(1'b1, 320);
    chk("R7", "skip cleared", int'(brk_skip_o), 0);
    send_sync(160, 160, 1'b0);
    drive(1'b1, 20);
    chk("R7", "div after skip", int'(div_o), 10);

    // R8: break without skip -> (320 + 7*160)/128 = 11
    arm(1'b0);
    drive(1'b0, 2080);
    drive(1'b1, 320);
    send_sync(160, 160, 1'b0);
    drive(1'b1, 20);
    chk("R8", "div break no skip", int'(div_o), 11);
    chk("R10", "tail edges ignored", int'(done_o), 1);

    // R2: re-arm on the fifth rising edge
    arm(1'b0);
    send_sync(160, 160, 1'b1);
    drive(1'b1, 20);
    chk("R2", "collision active", int'(active_o), 1);
    chk("R2", "collision done", int'(done_o), 0);
    chk("R2", "collision div", int'(div_o), 11);
    send_sync(208, 208, 1'b0);
    drive(1'b1, 20);
    chk("R2", "after collision div", int'(div_o), 13);

    // R9: saturation
    arm(1'b0);
    drive(1'b0, 50);
    drive(1'b1, 66000);
    chk("R9", "ovf", int'(ovf_o), 1);
    chk("R9", "active after ovf", int'(active_o), 0);
    chk("R9", "div kept", int'(div_o), 13);
    chk("R9", "done after ovf", int'(done_o), 0);

    finish_run();
  end
endmodule